// File: doc/BRIEF.md
# Exception Vector Dispatcher

This block takes one exception request per clock and, in the same edge, updates the processor state registers that a trap handler reads. The registers are the saved PCs, the cause codes, the faulting address, the saved status word and the processor status word (PS). The block also reports which handler vector the fetch logic must jump to. It accepts two kinds of request. A general exception goes to the kernel, user or double-fault vector, depending on the exception-mode and user-mode bits of PS. A debug exception goes to the debug vector, and only when the current interrupt level in PS is below the configured debug level.

PS is held inside the block. Software loads it through a single write port. A request that arrives in the same cycle as a PS write is dropped, so that a handler's own PS update is never mixed with a trap entry. All outputs are registered. The selected vector and the register values appear in the cycle after the request is sampled.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, vec_valid is 0 and every state register output (PS, EPC1, DEPC, EXCCAUSE, EXCVADDR, DBGCAUSE, EPC_DBG, EPS_DBG) is 0.
- R2: A general request with PS.EXCM (bit 4) clear writes req_pc to EPC1. It selects the user vector (vec_sel 1) when PS.UM (bit 5) is set, and the kernel vector (vec_sel 0) when it is clear.
- R3: A general request with PS.EXCM set selects the double vector (vec_sel 2). It writes req_pc to DEPC and leaves EPC1 unchanged when HAS_DEPC is 1. It writes req_pc to EPC1 when HAS_DEPC is 0.
- R4: Every accepted general request writes req_cause to EXCCAUSE and sets PS.EXCM. All other PS bits keep their values.
- R5: When req_vaddr_valid is 1, an accepted general request also writes req_vaddr to EXCVADDR. When it is 0, EXCVADDR is unchanged.
- R6: A debug request (req_debug 1) is accepted only when PS.INTLEVEL (bits 3:0) is below DBG_LEVEL. Otherwise it changes no register and raises no vec_valid.
- R7: An accepted debug request selects vec_sel 3. It writes req_cause to DBGCAUSE, req_pc to EPC_DBG and the old PS to EPS_DBG. It sets PS.INTLEVEL to DBG_LEVEL and sets PS.EXCM, and leaves EPC1, DEPC and EXCCAUSE unchanged.
- R8: vec_valid is 1 for exactly the one cycle after each accepted request and 0 after a cycle with no accepted request.
- R9: A request in the same cycle as ps_wr_en is ignored. PS takes ps_wr_data and no other register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request strobe |
| req_debug | input | 1 | 1: debug request, 0: general exception |
| req_cause | input | CAUSE_W | Cause code |
| req_pc | input | XLEN | PC of the excepting instruction |
| req_vaddr | input | XLEN | Faulting virtual address |
| req_vaddr_valid | input | 1 | req_vaddr is meaningful for this request |
| ps_wr_en | input | 1 | PS write strobe |
| ps_wr_data | input | 8 | New PS value |
| vec_valid | output | 1 | One-cycle vector-taken pulse |
| vec_sel | output | 2 | 0 kernel, 1 user, 2 double, 3 debug |
| ps_o | output | 8 | Processor status word |
| epc1_o | output | XLEN | Level-1 saved PC |
| depc_o | output | XLEN | Double-exception saved PC |
| exccause_o | output | CAUSE_W | General exception cause |
| excvaddr_o | output | XLEN | Faulting virtual address |
| dbgcause_o | output | CAUSE_W | Debug cause |
| epc_dbg_o | output | XLEN | Saved PC at the debug level |
| eps_dbg_o | output | 8 | Saved PS at the debug level |

## Verification
General requests are sent with PS in three states: both mode bits clear, only user mode set, and exception mode set. These three runs tell the kernel, user and double routes apart, and show that EPC1 is kept on a double fault. The same request is sent with and without an address, which shows whether EXCVADDR is updated. Debug requests are sent at interrupt levels below, equal to and above the debug level, which places the gate's threshold exactly. A request that coincides with a PS write shows that the write wins and the trap is dropped.

// File: rtl/exc_dispatch_pkg.sv
package exc_dispatch_pkg;
  localparam int PS_W     = 8;
  localparam int ILVL_LO  = 0;
  localparam int ILVL_W   = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // General trap entry: only the exception-mode bit changes
  function automatic logic [PS_W-1:0] ps_enter_exc(input logic [PS_W-1:0] ps);
    logic [PS_W-1:0] r;
    r = ps;
    r[EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // Debug entry: interrupt level forced to the debug level, exception mode set
  function automatic logic [PS_W-1:0] ps_enter_dbg(input logic [PS_W-1:0] ps,
                                                   input logic [ILVL_W-1:0] lvl);
    logic [PS_W-1:0] r;
    r = ps;
    r[ILVL_LO +: ILVL_W] = lvl;
    r[EXCM_BIT] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate
  import exc_dispatch_pkg::*;
#(
  parameter int DBG_LEVEL = 4
) (
  input  logic [PS_W-1:0] ps,
  output logic            allow
);
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);
  always_comb allow = (ps[ILVL_LO +: ILVL_W] < LVL);
endmodule

// File: rtl/exc_route.sv
module exc_route
  import exc_dispatch_pkg::*;
#(
  parameter bit HAS_DEPC = 1'b1
) (
  input  logic [PS_W-1:0] ps,
  input  logic            is_dbg,
  output vec_e            vec,
  output logic            save_depc,
  output logic            save_epc1
);
  logic nested;
  always_comb begin
    nested    = ps[EXCM_BIT];
    save_depc = 1'b0;
    save_epc1 = 1'b0;
    if (is_dbg) begin
      vec = VEC_DEBUG;
    end else if (nested) begin
      vec = VEC_DOUBLE;
      if (HAS_DEPC) save_depc = 1'b1;
      else          save_epc1 = 1'b1;
    end else begin
      vec = ps[UM_BIT] ? VEC_USER : VEC_KERNEL;
      save_epc1 = 1'b1;
    end
  end
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_dispatch_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBG_LEVEL = 4,   // legal range 2..6
  parameter bit HAS_DEPC  = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_debug,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic [XLEN-1:0]    req_pc,
  input  logic [XLEN-1:0]    req_vaddr,
  input  logic               req_vaddr_valid,
  input  logic               ps_wr_en,
  input  logic [PS_W-1:0]    ps_wr_data,
  output logic               vec_valid,
  output logic [1:0]         vec_sel,
  output logic [PS_W-1:0]    ps_o,
  output logic [XLEN-1:0]    epc1_o,
  output logic [XLEN-1:0]    depc_o,
  output logic [CAUSE_W-1:0] exccause_o,
  output logic [XLEN-1:0]    excvaddr_o,
  output logic [CAUSE_W-1:0] dbgcause_o,
  output logic [XLEN-1:0]    epc_dbg_o,
  output logic [PS_W-1:0]    eps_dbg_o
);
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

  logic dbg_allow, save_depc, save_epc1;
  vec_e route_vec;

  exc_dbg_gate #(.DBG_LEVEL(DBG_LEVEL)) u_gate (
    .ps(ps_o), .allow(dbg_allow)
  );

  exc_route #(.HAS_DEPC(HAS_DEPC)) u_route (
    .ps(ps_o), .is_dbg(req_debug), .vec(route_vec),
    .save_depc(save_depc), .save_epc1(save_epc1)
  );

  // Named events for the checker
  logic take_gen, take_dbg, take_any;
  always_comb begin
    take_gen = req_valid && !ps_wr_en && !req_debug;
    take_dbg = req_valid && !ps_wr_en && req_debug && dbg_allow;
    take_any = take_gen || take_dbg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid  <= 1'b0;
      vec_sel    <= VEC_KERNEL;
      ps_o       <= '0;
      epc1_o     <= '0;
      depc_o     <= '0;
      exccause_o <= '0;
      excvaddr_o <= '0;
      dbgcause_o <= '0;
      epc_dbg_o  <= '0;
      eps_dbg_o  <= '0;
    end else begin
      vec_valid <= take_any;
      if (take_any) vec_sel <= route_vec;
      if (ps_wr_en) begin
        ps_o <= ps_wr_data;
      end else if (take_gen) begin
        if (save_epc1) epc1_o <= req_pc;
        if (save_depc) depc_o <= req_pc;
        if (req_vaddr_valid) excvaddr_o <= req_vaddr;
        exccause_o <= req_cause;
        ps_o       <= ps_enter_exc(ps_o);
      end else if (take_dbg) begin
        dbgcause_o <= req_cause;
        epc_dbg_o  <= req_pc;
        eps_dbg_o  <= ps_o;
        ps_o       <= ps_enter_dbg(ps_o, LVL);
      end
    end
  end
endmodule

// File: rtl/exc_dispatch_chk.sv
module exc_dispatch_chk
  import exc_dispatch_pkg::*;
#(
  parameter int DBG_LEVEL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_debug,
  input logic            ps_wr_en,
  input logic [PS_W-1:0] ps_wr_data,
  input logic            take_any,
  input logic            vec_valid,
  input logic [1:0]      vec_sel,
  input logic [PS_W-1:0] ps_o
);
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

  assert_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ps_wr_en && !req_debug) |=> vec_valid);

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !take_any |=> !vec_valid);

  assert_wr_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ps_wr_en |=> (!vec_valid && ps_o == $past(ps_wr_data)));

  assert_excm_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_sel != VEC_DEBUG) |-> ps_o[EXCM_BIT]);

  assert_double_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_debug && !ps_wr_en && ps_o[EXCM_BIT]) |=> (vec_sel == VEC_DOUBLE));

  assert_dbg_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_debug && !ps_wr_en && ps_o[ILVL_LO +: ILVL_W] >= LVL)
      |=> (!vec_valid && $stable(ps_o)));

  assert_dbg_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_sel == VEC_DEBUG) |-> (ps_o[ILVL_LO +: ILVL_W] == LVL && ps_o[EXCM_BIT]));
endmodule

bind exc_dispatch exc_dispatch_chk #(.DBG_LEVEL(DBG_LEVEL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_debug(req_debug),
  .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data), .take_any(take_any),
  .vec_valid(vec_valid), .vec_sel(vec_sel), .ps_o(ps_o)
);

// File: tb/tb_exc_dispatch.sv
module tb_exc_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_debug = 1'b0, req_vaddr_valid = 1'b0;
  logic [5:0]  req_cause = '0;
  logic [31:0] req_pc = '0, req_vaddr = '0;
  logic        ps_wr_en = 1'b0;
  logic [7:0]  ps_wr_data = '0;
  logic        vec_valid;
  logic [1:0]  vec_sel;
  logic [7:0]  ps_o, eps_dbg_o;
  logic [31:0] epc1_o, depc_o, excvaddr_o, epc_dbg_o;
  logic [5:0]  exccause_o, dbgcause_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  exc_dispatch dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_debug(req_debug),
    .req_cause(req_cause), .req_pc(req_pc), .req_vaddr(req_vaddr),
    .req_vaddr_valid(req_vaddr_valid), .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data),
    .vec_valid(vec_valid), .vec_sel(vec_sel), .ps_o(ps_o), .epc1_o(epc1_o),
    .depc_o(depc_o), .exccause_o(exccause_o), .excvaddr_o(excvaddr_o),
    .dbgcause_o(dbgcause_o), .epc_dbg_o(epc_dbg_o), .eps_dbg_o(eps_dbg_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_ps(input logic [7:0] v);
    @(negedge clk); ps_wr_en = 1'b1; ps_wr_data = v;
    @(negedge clk); ps_wr_en = 1'b0;
  endtask

  // Drive one request for one cycle; returns at the negedge after the update edge
  task automatic fire(input bit dbg, input logic [5:0] c, input logic [31:0] pc,
                      input bit vv, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_debug = dbg; req_cause = c; req_pc = pc;
    req_vaddr_valid = vv; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; req_debug = 1'b0; req_vaddr_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 ps", 32'(ps_o), 0);
    chk("R1 epc1", epc1_o, 0);
    chk("R1 depc", depc_o, 0);
    chk("R1 exccause", 32'(exccause_o), 0);
    chk("R1 excvaddr", excvaddr_o, 0);
    chk("R1 dbgcause", 32'(dbgcause_o), 0);
    chk("R1 epc_dbg", epc_dbg_o, 0);
    chk("R1 eps_dbg", 32'(eps_dbg_o), 0);
  endtask

  task automatic t_kernel;
    fire(1'b0, 6'd5, 32'h0000_1000, 1'b0, 32'h0);
    chk("R8 pulse", 32'(vec_valid), 1);
    chk("R2 kernel vec", 32'(vec_sel), 0);
    chk("R2 epc1", epc1_o, 32'h0000_1000);
    chk("R4 cause", 32'(exccause_o), 5);
    chk("R4 ps excm", 32'(ps_o), 32'h10);
    chk("R5 no vaddr", excvaddr_o, 0);
    @(negedge clk);
    chk("R8 one cycle", 32'(vec_valid), 0);
  endtask

  task automatic t_user;
    write_ps(8'hA3);   // UM set, intlevel 3, upper bits set
    fire(1'b0, 6'd7, 32'h0000_2000, 1'b1, 32'hDEAD_0004);
    chk("R2 user vec", 32'(vec_sel), 1);
    chk("R2 epc1", epc1_o, 32'h0000_2000);
    chk("R4 other ps bits", 32'(ps_o), 32'hB3);
    chk("R5 vaddr", excvaddr_o, 32'hDEAD_0004);
  endtask

  task automatic t_double;
    // PS still has EXCM set from previous task
    fire(1'b0, 6'd9, 32'h0000_3000, 1'b0, 32'h0);
    chk("R3 double vec", 32'(vec_sel), 2);
    chk("R3 depc", depc_o, 32'h0000_3000);
    chk("R3 epc1 kept", epc1_o, 32'h0000_2000);
    chk("R4 cause", 32'(exccause_o), 9);
    chk("R5 vaddr kept", excvaddr_o, 32'hDEAD_0004);
  endtask

  task automatic t_debug_taken;
    write_ps(8'h03);   // intlevel 3 < 4
    fire(1'b1, 6'd2, 32'h0000_4000, 1'b1, 32'h1111_1111);
    chk("R7 debug vec", 32'(vec_sel), 3);
    chk("R6 accepted", 32'(vec_valid), 1);
    chk("R7 dbgcause", 32'(dbgcause_o), 2);
    chk("R7 epc_dbg", epc_dbg_o, 32'h0000_4000);
    chk("R7 eps_dbg", 32'(eps_dbg_o), 32'h03);
    chk("R7 ps", 32'(ps_o), 32'h14);
    chk("R7 exccause kept", 32'(exccause_o), 9);
    chk("R7 epc1 kept", epc1_o, 32'h0000_2000);
  endtask

  task automatic t_debug_blocked(input logic [7:0] psv);
    write_ps(psv);
    fire(1'b1, 6'd6, 32'h0000_5000, 1'b0, 32'h0);
    chk("R6 no pulse", 32'(vec_valid), 0);
    chk("R6 ps kept", 32'(ps_o), 32'(psv));
    chk("R6 dbgcause kept", 32'(dbgcause_o), 2);
    chk("R6 epc_dbg kept", epc_dbg_o, 32'h0000_4000);
  endtask

  task automatic t_collide;
    @(negedge clk);
    req_valid = 1'b1; req_debug = 1'b0; req_cause = 6'd11; req_pc = 32'h0000_6000;
    ps_wr_en = 1'b1; ps_wr_data = 8'h21;
    @(negedge clk);
    req_valid = 1'b0; ps_wr_en = 1'b0;
    chk("R9 no pulse", 32'(vec_valid), 0);
    chk("R9 ps written", 32'(ps_o), 32'h21);
    chk("R9 epc1 kept", epc1_o, 32'h0000_2000);
    chk("R9 cause kept", 32'(exccause_o), 9);
  endtask

  task automatic t_back_to_back;
    write_ps(8'h00);
    @(negedge clk);
    req_valid = 1'b1; req_debug = 1'b0; req_cause = 6'd1; req_pc = 32'h0000_7000;
    @(negedge clk);
    chk("R8 first", 32'(vec_valid), 1);
    chk("R2 first kernel", 32'(vec_sel), 0);
    req_cause = 6'd2; req_pc = 32'h0000_8000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 second", 32'(vec_valid), 1);
    chk("R3 second double", 32'(vec_sel), 2);
    chk("R3 depc second", depc_o, 32'h0000_8000);
    @(negedge clk);
    chk("R8 drops", 32'(vec_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_kernel();
    t_user();
    t_double();
    t_debug_taken();
    t_debug_blocked(8'h04);  // equal to debug level
    t_debug_blocked(8'h05);  // above debug level
    t_collide();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule